// File: doc/BRIEF.md
# Byte-Loading Dual DAC Write Sequencer

This block sits on the host side of a dual 12-bit converter that is loaded one byte at a time. It takes a request from a valid/ready port: a 12-bit code, a two-bit channel mask, an update flag and a clear flag. It then drives the converter's parallel bus: an 8-bit data bus, two address lines, and active-low chip select, write, update and clear strobes. For each selected channel it writes the low eight bits first and then the top four bits. When the update flag is set, it finishes with one shared update strobe so that both converter outputs change together.

All bus timing is given in nanoseconds as parameters. The block turns each figure into a whole number of clock cycles using a clock-period parameter. The rules it keeps are: address setup before the write strobe falls, a write low time that also covers data setup, a hold time after the write strobe rises that covers both address and data hold, and a minimum clear pulse width. The request port stays busy until the last strobe of the request has been released.

Top module: `dacByteWriter`

## Requirements
- R1: While reset is asserted, csN, wrN, updN and clrN are high, reqReady is high, and busData and busAddr are zero.
- R2: Each timing figure becomes max(1, ceil(ns / CLK_PERIOD_NS)) cycles. Setup is the address-setup count. The write-low time is the larger of the write-pulse and data-setup counts. The post-write hold is the larger of the address-hold and data-hold counts. Every write strobe stays low for exactly the write-low count.
- R3: The first access for a channel is its low byte. busAddr is 2'b00 for channel A and 2'b10 for channel B, and busData is value[7:0].
- R4: The second access for a channel is its high nibble. busAddr is 2'b01 for channel A and 2'b11 for channel B. busData[3:0] is value[11:8] and busData[7:4] is zero.
- R5: Each access drives busAddr, busData and its select strobe for the setup count with wrN high, then the write-low count with wrN low, then the hold count with wrN high. busAddr and busData do not change within that window.
- R6: reqChanSel bit 0 selects channel A and bit 1 selects channel B. When both bits are set, both channel A accesses come before both channel B accesses, and all four carry the same value.
- R7: With reqUpdate set, one update access follows the byte writes, with updN low and csN high and the same setup, write-low and hold counts. During byte writes csN is low and updN is high. The two are never low together.
- R8: reqReady is high only when every strobe is released. It goes low in the cycle after a request is accepted and rises in the cycle after the last hold or clear cycle.
- R9: With reqClear set, clrN is low for the clear count with all other strobes high. Clear takes priority: the channel and update fields of that request are ignored.
- R10: An update access and idle cycles keep busAddr and busData at the last values driven.
- R11: A request with no channel, no update and no clear is accepted with no strobe activity, and reqReady stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle and able to accept a request |
| reqValue | input | 12 | Code to load into the selected channels |
| reqChanSel | input | 2 | Channel mask, bit 0 = A, bit 1 = B |
| reqUpdate | input | 1 | Issue a shared update strobe after the writes |
| reqClear | input | 1 | Issue a clear pulse only |
| busData | output | 8 | Converter data bus |
| busAddr | output | 2 | Converter address lines (bit 1 channel, bit 0 nibble) |
| csN | output | 1 | Chip select, active low |
| wrN | output | 1 | Write strobe, active low |
| updN | output | 1 | Update strobe, active low |
| clrN | output | 1 | Clear strobe, active low |

## Verification
The bench builds the block with an 8 ns clock period and sets the address setup and address hold figures to zero. This drives both figures through the one-cycle floor of the conversion. The hold stretch comes out at four cycles, set by the data-hold figure, so the larger-of selection can be seen at the ports. The write-low time is sixteen cycles and the clear pulse is thirteen, which is long enough for a reference model to catch an off-by-one in any phase on every clock.

// File: rtl/dacSeqPkg.sv
package dacSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_CLEAR
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // take reqValue into the value register
    logic drive;     // put a byte and its address on the bus
    logic msNibble;  // 1: upper nibble, 0: low byte
    logic chanB;     // 1: channel B, 0: channel A
  } seqCtl_t;

  // access steps of one request, in issue order
  localparam logic [2:0] STEP_A_LO  = 3'd0;
  localparam logic [2:0] STEP_UPD   = 3'd4;
  localparam logic [2:0] STEP_NONE  = 3'd5;

  function automatic int unsigned nsToCycles(int unsigned ns, int unsigned periodNs);
    int unsigned c;
    c = (ns + periodNs - 1) / periodNs;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned maxU(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seqTimer.sv
module seqTimer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [CNT_W-1:0] loadVal,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (load)        cnt <= loadVal;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/seqControl.sv
module seqControl
  import dacSeqPkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int WR_CYC    = 16,
  parameter int HOLD_CYC  = 4,
  parameter int CLR_CYC   = 13,
  parameter int CNT_W     = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqChanSel,
  input  logic       reqUpdate,
  input  logic       reqClear,
  output logic       reqReady,
  output logic       csN,
  output logic       wrN,
  output logic       updN,
  output logic       clrN,
  output seqCtl_t    ctl
);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LD    = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] CLR_LD   = CNT_W'(CLR_CYC - 1);

  seqState_e        state, nState;
  logic [2:0]       step, nStep;
  logic [1:0]       jobChan, nJobChan;
  logic             jobUpd, nJobUpd;
  logic             nCs, nWr, nUpd, nClr;
  logic             tLoad, tDone;
  logic [CNT_W-1:0] tVal;
  logic             goValid;
  logic [2:0]       goStep, firstStep, followStep;

  // first enabled step at or after 'from'
  function automatic logic [2:0] pickStep(logic [2:0] from, logic [1:0] ch, logic upd);
    logic [2:0] r;
    logic       ok;
    r = STEP_NONE;
    for (int s = 4; s >= 0; s--) begin
      ok = (s < 2) ? ch[0] : ((s < 4) ? ch[1] : upd);
      if ((s >= int'(from)) && ok) r = s[2:0];
    end
    return r;
  endfunction

  assign firstStep  = pickStep(STEP_A_LO, reqChanSel, reqUpdate);
  assign followStep = pickStep(step + 3'd1, jobChan, jobUpd);

  seqTimer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rstN(rstN), .load(tLoad), .loadVal(tVal), .done(tDone)
  );

  always_comb begin
    nState   = state;
    nStep    = step;
    nJobChan = jobChan;
    nJobUpd  = jobUpd;
    nCs      = csN;
    nWr      = wrN;
    nUpd     = updN;
    nClr     = clrN;
    tLoad    = 1'b0;
    tVal     = '0;
    ctl      = '0;
    goValid  = 1'b0;
    goStep   = STEP_NONE;

    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (reqClear) begin
            nState = ST_CLEAR;
            nClr   = 1'b0;
            tLoad  = 1'b1;
            tVal   = CLR_LD;
          end else begin
            nJobChan    = reqChanSel;
            nJobUpd     = reqUpdate;
            ctl.capture = 1'b1;
            goValid     = 1'b1;
            goStep      = firstStep;
          end
        end
      end
      ST_SETUP: begin
        if (tDone) begin
          nState = ST_STROBE;
          nWr    = 1'b0;
          tLoad  = 1'b1;
          tVal   = WR_LD;
        end
      end
      ST_STROBE: begin
        if (tDone) begin
          nState = ST_HOLD;
          nWr    = 1'b1;
          tLoad  = 1'b1;
          tVal   = HOLD_LD;
        end
      end
      ST_HOLD: begin
        if (tDone) begin
          goValid = 1'b1;
          goStep  = followStep;
        end
      end
      ST_CLEAR: begin
        if (tDone) begin
          nState = ST_IDLE;
          nClr   = 1'b1;
        end
      end
      default: nState = ST_IDLE;
    endcase

    if (goValid) begin
      if (goStep == STEP_NONE) begin
        nState = ST_IDLE;
        nCs    = 1'b1;
        nUpd   = 1'b1;
      end else begin
        nState = ST_SETUP;
        nStep  = goStep;
        tLoad  = 1'b1;
        tVal   = SETUP_LD;
        if (goStep == STEP_UPD) begin
          nCs  = 1'b1;
          nUpd = 1'b0;
        end else begin
          nCs          = 1'b0;
          nUpd         = 1'b1;
          ctl.drive    = 1'b1;
          ctl.msNibble = goStep[0];
          ctl.chanB    = goStep[1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      step    <= STEP_NONE;
      jobChan <= '0;
      jobUpd  <= 1'b0;
      csN     <= 1'b1;
      wrN     <= 1'b1;
      updN    <= 1'b1;
      clrN    <= 1'b1;
    end else begin
      state   <= nState;
      step    <= nStep;
      jobChan <= nJobChan;
      jobUpd  <= nJobUpd;
      csN     <= nCs;
      wrN     <= nWr;
      updN    <= nUpd;
      clrN    <= nClr;
    end
  end

  assign reqReady = (state == ST_IDLE);
endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import dacSeqPkg::*;
#(
  parameter int VALUE_W = 12,
  parameter int BUS_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [VALUE_W-1:0] reqValue,
  input  seqCtl_t            ctl,
  output logic [BUS_W-1:0]   busData,
  output logic [1:0]         busAddr
);
  localparam int MS_W = VALUE_W - BUS_W;

  logic [VALUE_W-1:0] valReg;
  logic [VALUE_W-1:0] src;
  logic [BUS_W-1:0]   lowByte, highNib;

  assign src     = ctl.capture ? reqValue : valReg;
  assign lowByte = src[BUS_W-1:0];
  assign highNib = {{(BUS_W-MS_W){1'b0}}, src[VALUE_W-1:BUS_W]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valReg  <= '0;
      busData <= '0;
      busAddr <= '0;
    end else begin
      if (ctl.capture) valReg <= reqValue;
      if (ctl.drive) begin
        busData <= ctl.msNibble ? highNib : lowByte;
        busAddr <= {ctl.chanB, ctl.msNibble};
      end
    end
  end
endmodule

// File: rtl/dacByteWriter.sv
module dacByteWriter
  import dacSeqPkg::*;
#(
  parameter int CLK_PERIOD_NS = 8,
  parameter int ADDR_SETUP_NS = 10,
  parameter int ADDR_HOLD_NS  = 10,
  parameter int DATA_SETUP_NS = 40,
  parameter int DATA_HOLD_NS  = 30,
  parameter int WR_PULSE_NS   = 125,
  parameter int CLR_PULSE_NS  = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [11:0] reqValue,
  input  logic [1:0]  reqChanSel,
  input  logic        reqUpdate,
  input  logic        reqClear,
  output logic [7:0]  busData,
  output logic [1:0]  busAddr,
  output logic        csN,
  output logic        wrN,
  output logic        updN,
  output logic        clrN
);
  localparam int VALUE_W   = 12;
  localparam int BUS_W     = 8;
  localparam int SETUP_CYC = nsToCycles(ADDR_SETUP_NS, CLK_PERIOD_NS);
  localparam int WR_CYC    = maxU(nsToCycles(WR_PULSE_NS, CLK_PERIOD_NS),
                                  nsToCycles(DATA_SETUP_NS, CLK_PERIOD_NS));
  localparam int HOLD_CYC  = maxU(nsToCycles(ADDR_HOLD_NS, CLK_PERIOD_NS),
                                  nsToCycles(DATA_HOLD_NS, CLK_PERIOD_NS));
  localparam int CLR_CYC   = nsToCycles(CLR_PULSE_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC   = maxU(maxU(SETUP_CYC, WR_CYC), maxU(HOLD_CYC, CLR_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  seqCtl_t ctl;

  seqControl #(
    .SETUP_CYC(SETUP_CYC), .WR_CYC(WR_CYC), .HOLD_CYC(HOLD_CYC),
    .CLR_CYC(CLR_CYC), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqChanSel(reqChanSel),
    .reqUpdate(reqUpdate), .reqClear(reqClear), .reqReady(reqReady),
    .csN(csN), .wrN(wrN), .updN(updN), .clrN(clrN), .ctl(ctl)
  );

  seqDatapath #(.VALUE_W(VALUE_W), .BUS_W(BUS_W)) dp_i (
    .clk(clk), .rstN(rstN), .reqValue(reqValue), .ctl(ctl),
    .busData(busData), .busAddr(busAddr)
  );
endmodule

// File: rtl/seqChecker.sv
module seqChecker #(
  parameter int SETUP_CYC = 2,
  parameter int WR_CYC    = 16,
  parameter int CLR_CYC   = 13,
  parameter int CNT_W     = 5
) (
  input logic       clk,
  input logic       rstN,
  input logic       reqReady,
  input logic [7:0] busData,
  input logic [1:0] busAddr,
  input logic       csN,
  input logic       wrN,
  input logic       updN,
  input logic       clrN
);
  logic [CNT_W-1:0] lowCnt, clrCnt, setCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
      clrCnt <= '0;
      setCnt <= '0;
    end else begin
      lowCnt <= !wrN ? ((lowCnt != '1) ? lowCnt + 1'b1 : lowCnt) : '0;
      clrCnt <= !clrN ? ((clrCnt != '1) ? clrCnt + 1'b1 : clrCnt) : '0;
      setCnt <= (wrN && (!csN || !updN)) ? ((setCnt != '1) ? setCnt + 1'b1 : setCnt) : '0;
    end
  end

  p_wr_width_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrN) |-> (lowCnt == CNT_W'(WR_CYC)));

  p_setup_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrN) |-> (setCnt >= CNT_W'(SETUP_CYC)));

  p_bus_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> ($stable(busAddr) && $stable(busData)));

  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrN) |-> ($stable(busAddr) && $stable(busData) && (!csN || !updN)));

  p_cs_upd_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    (csN || updN));

  p_wr_target_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrN) |-> (csN != updN));

  p_clr_width_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clrN) |-> (clrCnt == CNT_W'(CLR_CYC)));

  p_clr_alone_r9: assert property (@(posedge clk) disable iff (!rstN)
    !clrN |-> (csN && wrN && updN));

  p_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!csN || !wrN || !updN || !clrN) |-> !reqReady);
endmodule

bind dacByteWriter seqChecker #(
  .SETUP_CYC(SETUP_CYC), .WR_CYC(WR_CYC), .CLR_CYC(CLR_CYC), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .busData(busData),
  .busAddr(busAddr), .csN(csN), .wrN(wrN), .updN(updN), .clrN(clrN)
);

// File: tb/dacByteWriter_test.sv
module dacByteWriter_test;
  localparam int PER_NS = 8;
  localparam int AS_NS = 0, AH_NS = 0, DS_NS = 40, DH_NS = 30, WP_NS = 125, CP_NS = 100;

  function automatic int bCyc(int ns);
    int c;
    c = (ns + PER_NS - 1) / PER_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int S_CYC = bCyc(AS_NS);
  localparam int W_CYC = (bCyc(WP_NS) > bCyc(DS_NS)) ? bCyc(WP_NS) : bCyc(DS_NS);
  localparam int H_CYC = (bCyc(AH_NS) > bCyc(DH_NS)) ? bCyc(AH_NS) : bCyc(DH_NS);
  localparam int C_CYC = bCyc(CP_NS);

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqUpdate = 1'b0, reqClear = 1'b0;
  logic [11:0] reqValue = '0;
  logic [1:0]  reqChanSel = '0;
  logic reqReady, csN, wrN, updN, clrN;
  logic [7:0] busData;
  logic [1:0] busAddr;

  int total = 0, bad = 0;
  bit running = 0, finished = 0;
  logic [14:0] expQ[$];
  string tagQ[$];
  logic [1:0] lastA = '0;
  logic [7:0] lastD = '0;

  always #4 clk = ~clk;

  dacByteWriter #(
    .CLK_PERIOD_NS(PER_NS), .ADDR_SETUP_NS(AS_NS), .ADDR_HOLD_NS(AH_NS),
    .DATA_SETUP_NS(DS_NS), .DATA_HOLD_NS(DH_NS), .WR_PULSE_NS(WP_NS),
    .CLR_PULSE_NS(CP_NS)
  ) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqValue(reqValue), .reqChanSel(reqChanSel), .reqUpdate(reqUpdate),
    .reqClear(reqClear), .busData(busData), .busAddr(busAddr),
    .csN(csN), .wrN(wrN), .updN(updN), .clrN(clrN)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] pack(bit rdy, bit cs, bit wr, bit upd, bit clr,
                                       logic [1:0] a, logic [7:0] d);
    return {rdy, cs, wr, upd, clr, a, d};
  endfunction

  task automatic pushVec(logic [14:0] v, string tag);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  // behavioural model of one access
  task automatic modelStep(int s, logic [11:0] v, string tag);
    bit cs, upd;
    logic [1:0] a;
    logic [7:0] d;
    if (s < 4) begin
      a = (s >= 2) ? ((s == 3) ? 2'b11 : 2'b10) : ((s == 1) ? 2'b01 : 2'b00);
      d = (s % 2 == 1) ? {4'h0, v[11:8]} : v[7:0];
      lastA = a;
      lastD = d;
      cs = 0; upd = 1;
    end else begin
      a = lastA; d = lastD;
      cs = 1; upd = 0;
    end
    for (int i = 0; i < S_CYC; i++) pushVec(pack(0, cs, 1, upd, 1, a, d), tag);
    for (int i = 0; i < W_CYC; i++) pushVec(pack(0, cs, 0, upd, 1, a, d), "R2");
    for (int i = 0; i < H_CYC; i++) pushVec(pack(0, cs, 1, upd, 1, a, d), "R5");
  endtask

  task automatic modelJob(logic [1:0] ch, logic [11:0] v, bit upd, bit clr);
    if (clr) begin
      for (int i = 0; i < C_CYC; i++) pushVec(pack(0, 1, 1, 1, 0, lastA, lastD), "R9");
    end else begin
      if (ch[0]) begin modelStep(0, v, "R3"); modelStep(1, v, "R4"); end
      if (ch[1]) begin modelStep(2, v, "R6"); modelStep(3, v, "R6"); end
      if (upd) modelStep(4, v, "R7");
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (running) begin
      logic [14:0] act, exp;
      string tag;
      act = {reqReady, csN, wrN, updN, clrN, busAddr, busData};
      if (expQ.size() > 0) begin
        exp = expQ.pop_front();
        tag = tagQ.pop_front();
      end else begin
        exp = pack(1, 1, 1, 1, 1, lastA, lastD);
        tag = "R8";
      end
      chk(act == exp, tag, 32'(act), 32'(exp));
    end
  end

  task automatic send(logic [1:0] ch, logic [11:0] v, bit upd, bit clr);
    @(negedge clk);
    reqValid = 1; reqChanSel = ch; reqValue = v; reqUpdate = upd; reqClear = clr;
    @(posedge clk);
    modelJob(ch, v, upd, clr);
    #1 reqValid = 0;
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({reqReady, csN, wrN, updN, clrN} == 5'b11111, "R1", 32'({reqReady, csN, wrN, updN, clrN}), 32'h1f);
    chk({busAddr, busData} == 10'd0, "R1", 32'({busAddr, busData}), 32'h0);
    @(negedge clk) rstN = 1;
    running = 1;
    repeat (2) @(negedge clk);

    send(2'b01, 12'hABC, 0, 0);   // channel A only, R3 R4
    send(2'b10, 12'h5A3, 1, 0);   // channel B plus update
    send(2'b11, 12'hFFF, 1, 0);   // both plus update, R6 R7
    send(2'b11, 12'h000, 0, 0);   // both, no update
    send(2'b01, 12'h801, 0, 0);

    // R10: update-only access keeps bus values
    send(2'b00, 12'h123, 1, 0);
    chk({busAddr, busData} == {2'b01, 8'h08}, "R10", 32'({busAddr, busData}), 32'({2'b01, 8'h08}));

    // R9: clear, then clear with other fields set
    send(2'b00, 12'h000, 0, 1);
    send(2'b11, 12'h777, 1, 1);
    chk({busAddr, busData} == {2'b01, 8'h08}, "R9", 32'({busAddr, busData}), 32'({2'b01, 8'h08}));

    // R11: empty request
    send(2'b00, 12'hFFF, 0, 0);
    chk({reqReady, csN, wrN, updN, clrN} == 5'b11111, "R11", 32'({reqReady, csN, wrN, updN, clrN}), 32'h1f);
    chk({busAddr, busData} == {2'b01, 8'h08}, "R11", 32'({busAddr, busData}), 32'({2'b01, 8'h08}));

    send(2'b10, 12'h3C5, 0, 0);
    running = 0;
    finish();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog act=hung exp=done");
      finish();
    end
  end
endmodule